// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router maps four shared, level-sensitive PCI interrupt request lines onto sixteen legacy interrupt controller inputs. Each request line has one byte-wide routing register. A value below 16 selects the output that the line drives. A value of 16 or more disables the line. Several request lines may select the same output, and that output is then the wired-OR of them. The block keeps one level bit for every (output, line) pair in a 64-entry bitmap indexed by `output*4 + line`. Each output is the OR of its four bits.

The routing registers are written through a dword configuration write port that has per-byte enables. Any write that touches the routing dword rebuilds the whole bitmap in the following cycle from the live request levels. Two combinational helpers sit beside the router:
- a query port that reports, for one request line, whether it is enabled and which output it drives;
- a swizzle that turns a device/function number and an INTx pin into a request line index.

Top module: `pirq_router`

## Requirements
- R1: In steady state, output `irq_o[i]` is high exactly when at least one enabled request line whose routing register equals i is high. Lines that share an output combine as an OR, and a line drives at most one output.
- R2: A level change on `pirq_i` appears at `irq_o` after exactly one rising clock edge.
- R3: A routing value of 16 or more disables its line. The line's level is ignored and it drives no output.
- R4: A write with `cfg_addr_i[7:2] == 6'h18` (byte address 0x60) writes byte lane k of `cfg_wdata_i` (bits 8k+7:8k) into the routing register of line k, with line A = lane 0 through line D = lane 3, only where `cfg_be_i[k]` is set. A write to any other address leaves the routing registers unchanged.
- R5: Reset, which is asynchronous and active-low, sets all four routing registers to 0x80 and drives every output low.
- R6: A write that hits the routing dword on clock edge T leaves `irq_o` under the old routing after T. After edge T+1 the bitmap has been cleared and refilled from the live line levels under the new routing.
- R7: `swz_pirq_o = (swz_intx_i + swz_devfn_i[7:3] - 1) mod 4`, where INTA..INTD are coded 0..3.
- R8: For the line `qry_pin_i` (0 = A .. 3 = D), `qry_en_o` is 1 with `qry_irq_o` = the routed output number when the line is enabled. When the line is disabled, `qry_en_o` is 0 and `qry_irq_o` is 5'h1F, that is -1 in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pirq_i | input | 4 | Request line levels, active high, bit 0 = line A |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address, dword aligned |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_be_i | input | 4 | Byte enables, bit k = byte lane k |
| qry_pin_i | input | 2 | Request line to query |
| qry_en_o | output | 1 | Queried line is enabled |
| qry_irq_o | output | 5 | Output number of queried line, 5'h1F when disabled |
| swz_devfn_i | input | 8 | Device/function number for the swizzle |
| swz_intx_i | input | 2 | INTx pin for the swizzle, 0 = INTA |
| swz_pirq_o | output | 2 | Request line index from the swizzle |
| irq_o | output | 16 | Legacy interrupt controller inputs |

## Verification
A stale or misplaced bitmap bit shows at the ports as an output that stays high after its line has dropped, or that stays high after the line was re-routed or disabled. Such an error is visible one edge after a level change, or two edges after a routing write. Shared outputs, disabled lines with live levels, and partial byte-enable writes are therefore checked after a settled wait. The rebuild instant itself is checked at the exact edge. A wrong routing register also shows at the query port in the same cycle.

// File: rtl/pirq_rtr_pkg.sv
package pirq_rtr_pkg;
  localparam int ROUTE_W = 8;
  typedef logic [ROUTE_W-1:0] route_t;
  localparam route_t ROUTE_RST = 8'h80;
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_rtr_pkg::*;
#(
  parameter int N_PIRQ = 4,
  parameter int N_IRQ  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  localparam int LANES  = DATA_W / 8,
  localparam int PIRQ_W = $clog2(N_PIRQ),
  localparam int IRQ_W  = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [LANES-1:0]  cfg_be_i,
  input  logic [PIRQ_W-1:0] qry_pin_i,
  output logic              qry_en_o,
  output logic [IRQ_W:0]    qry_irq_o,
  output route_t            route_o [N_PIRQ],
  output logic              rebuild_o
);
  route_t route_q [N_PIRQ];
  logic   rebuild_q;
  logic   wr_hit;

  assign wr_hit = cfg_we_i && (cfg_addr_i[ADDR_W-1:2] == BASE[ADDR_W-1:2])
                  && |cfg_be_i[N_PIRQ-1:0];

  for (genvar p = 0; p < N_PIRQ; p++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     route_q[p] <= ROUTE_RST;
      else if (wr_hit && cfg_be_i[p])  route_q[p] <= cfg_wdata_i[8*p +: 8];
    end
    assign route_o[p] = route_q[p];

    assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_hit && cfg_be_i[p]) |=> $stable(route_q[p]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rebuild_q <= 1'b0;
    else         rebuild_q <= wr_hit;
  end
  assign rebuild_o = rebuild_q;

  // query: disabled reads back as all ones (-1)
  always_comb begin
    qry_en_o  = (int'(route_q[qry_pin_i]) < N_IRQ);
    qry_irq_o = qry_en_o ? {1'b0, route_q[qry_pin_i][IRQ_W-1:0]} : '1;
  end

  logic unused_bits;
  assign unused_bits = ^{cfg_addr_i[1:0], cfg_be_i, cfg_wdata_i};

  assert_rebuild_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> rebuild_o);
  assert_no_rebuild_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> !rebuild_o);
  always_comb if (rst_ni && !qry_en_o) assert_qry_neg_R8: assert (&qry_irq_o);
endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_rtr_pkg::*;
#(
  parameter int N_PIRQ = 4,
  parameter int N_IRQ  = 16,
  localparam int MAP_W = N_PIRQ * N_IRQ,
  localparam int IRQ_W = $clog2(N_IRQ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIRQ-1:0] pirq_i,
  input  route_t            route_i [N_PIRQ],
  input  logic              rebuild_i,
  output logic [N_IRQ-1:0]  irq_o
);
  logic [MAP_W-1:0] lvl_q, lvl_d;
  logic [N_IRQ-1:0] irq_q, irq_d;

  // rebuild clears everything; otherwise each enabled line rewrites its own bit
  always_comb begin
    lvl_d = rebuild_i ? '0 : lvl_q;
    for (int p = 0; p < N_PIRQ; p++) begin
      if (int'(route_i[p]) < N_IRQ)
        lvl_d[int'(route_i[p][IRQ_W-1:0]) * N_PIRQ + p] = pirq_i[p];
    end
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_or
    assign irq_d[i] = |lvl_d[i*N_PIRQ +: N_PIRQ];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      irq_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      irq_q <= irq_d;
    end
  end
  assign irq_o = irq_q;

  logic [N_IRQ-1:0] col [N_PIRQ];
  always_comb begin
    for (int p = 0; p < N_PIRQ; p++)
      for (int i = 0; i < N_IRQ; i++)
        col[p][i] = lvl_q[i*N_PIRQ + p];
  end

  for (genvar p = 0; p < N_PIRQ; p++) begin : g_chk
    assert_one_irq_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(col[p]) <= 1);
    assert_disabled_col_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rebuild_i && int'(route_i[p]) >= N_IRQ) |=> (col[p] == '0));
  end
  for (genvar i = 0; i < N_IRQ; i++) begin : g_chk_or
    assert_or_match_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] == |lvl_q[i*N_PIRQ +: N_PIRQ]);
  end
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle #(
  parameter int N_PIRQ = 4,
  localparam int PIRQ_W = $clog2(N_PIRQ)
) (
  input  logic [7:0]        devfn_i,
  input  logic [PIRQ_W-1:0] intx_i,
  output logic [PIRQ_W-1:0] pirq_o
);
  logic [PIRQ_W-1:0] slot_lo;
  assign slot_lo = devfn_i[3 +: PIRQ_W];
  // modulo by truncation (N_PIRQ is a power of two)
  assign pirq_o  = intx_i + slot_lo - PIRQ_W'(1);

  logic unused_devfn;
  assign unused_devfn = ^devfn_i;
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_rtr_pkg::*;
#(
  parameter int N_PIRQ = 4,
  parameter int N_IRQ  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 8'h60,
  localparam int PIRQ_W = $clog2(N_PIRQ),
  localparam int IRQ_W  = $clog2(N_IRQ),
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PIRQ-1:0] pirq_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  input  logic [LANES-1:0]  cfg_be_i,
  input  logic [PIRQ_W-1:0] qry_pin_i,
  output logic              qry_en_o,
  output logic [IRQ_W:0]    qry_irq_o,
  input  logic [7:0]        swz_devfn_i,
  input  logic [PIRQ_W-1:0] swz_intx_i,
  output logic [PIRQ_W-1:0] swz_pirq_o,
  output logic [N_IRQ-1:0]  irq_o
);
  route_t route [N_PIRQ];
  logic   rebuild;

  pirq_route_regs #(.N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ), .ADDR_W(ADDR_W),
                    .DATA_W(DATA_W), .BASE(BASE)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_be_i,
    .qry_pin_i, .qry_en_o, .qry_irq_o,
    .route_o(route), .rebuild_o(rebuild)
  );

  pirq_level_map #(.N_PIRQ(N_PIRQ), .N_IRQ(N_IRQ)) u_map (
    .clk_i, .rst_ni, .pirq_i, .route_i(route), .rebuild_i(rebuild), .irq_o
  );

  pirq_swizzle #(.N_PIRQ(N_PIRQ)) u_swz (
    .devfn_i(swz_devfn_i), .intx_i(swz_intx_i), .pirq_o(swz_pirq_o)
  );
endmodule

// File: tb/pirq_router_test.sv
`timescale 1ns/1ps
module pirq_router_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  pirq = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [1:0]  qpin = '0;
  logic        qen;
  logic [4:0]  qirq;
  logic [7:0]  devfn = '0;
  logic [1:0]  intx = '0;
  logic [1:0]  spirq;
  logic [15:0] irq;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pirq_router uut (
    .clk_i(clk), .rst_ni, .pirq_i(pirq), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .cfg_be_i(be), .qry_pin_i(qpin), .qry_en_o(qen),
    .qry_irq_o(qirq), .swz_devfn_i(devfn), .swz_intx_i(intx),
    .swz_pirq_o(spirq), .irq_o(irq)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [3:0]  lvl;
    logic [15:0] exp;
  } vec_t;

  // routes accumulate; comments give A,B,C,D after the step
  localparam vec_t VEC [12] = '{
    '{1'b0, 8'h60, 4'h0, 32'h0,         4'hF, 16'h0000}, // all 0x80: R3
    '{1'b1, 8'h60, 4'hF, 32'h0B0A0509, 4'hF, 16'h0E20}, // 9,5,10,11: R4
    '{1'b0, 8'h60, 4'h0, 32'h0,         4'h5, 16'h0600},
    '{1'b1, 8'h60, 4'h2, 32'h00000900, 4'h2, 16'h0200}, // B=9 lane1
    '{1'b0, 8'h60, 4'h0, 32'h0,         4'h3, 16'h0200}, // shared: R1
    '{1'b0, 8'h60, 4'h0, 32'h0,         4'h1, 16'h0200},
    '{1'b1, 8'h60, 4'h8, 32'h10000000, 4'h8, 16'h0000}, // D=0x10: R3
    '{1'b1, 8'h60, 4'h4, 32'h00FF0000, 4'hF, 16'h0200}, // C=0xFF
    '{1'b1, 8'h64, 4'hF, 32'h00000000, 4'hF, 16'h0200}, // other dword: R4
    '{1'b1, 8'h60, 4'h0, 32'h00000000, 4'h6, 16'h0200}, // no lanes: R4
    '{1'b1, 8'h60, 4'h1, 32'h0000000F, 4'h1, 16'h8000}, // A=15
    '{1'b0, 8'h60, 4'h0, 32'h0,         4'h3, 16'h8200}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5/R8 reset state
    chk("R5 irq after reset", 32'(irq), 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 irq idle", 32'(irq), 32'h0);
    for (int p = 0; p < 4; p++) begin
      qpin = 2'(p); #1;
      chk("R5 R8 reset query en", 32'(qen), 32'h0);
      chk("R8 reset query irq", 32'(qirq), 32'h1F);
    end

    // table walk: R1, R3, R4
    foreach (VEC[k]) begin
      @(negedge clk);
      we = VEC[k].we; addr = VEC[k].addr; be = VEC[k].be;
      wdata = VEC[k].data; pirq = VEC[k].lvl;
      @(negedge clk);
      we = 1'b0; be = '0;
      repeat (2) @(negedge clk);
      chk("R1 R3 R4 vector", 32'(irq), 32'(VEC[k].exp));
    end

    // R8 query: A=15, B=9, C=0xFF, D=0x10
    qpin = 2'd0; #1;
    chk("R8 query A en", 32'(qen), 32'h1);
    chk("R8 query A irq", 32'(qirq), 32'd15);
    qpin = 2'd1; #1;
    chk("R4 R8 query B irq", 32'(qirq), 32'd9);
    qpin = 2'd2; #1;
    chk("R8 query C disabled", 32'({qen, qirq}), 32'h1F);
    qpin = 2'd3; #1;
    chk("R8 query D disabled", 32'({qen, qirq}), 32'h1F);

    // R2 one-edge latency (irq is 0x8200 with pirq=0011)
    @(negedge clk);
    pirq = 4'b0010;
    #1 chk("R2 before edge", 32'(irq), 32'h8200);
    @(posedge clk); #1;
    chk("R2 after one edge", 32'(irq), 32'h0200);

    // R6 rebuild timing: A moves 15 -> 3 with A high, B low
    @(negedge clk);
    pirq = 4'b0001; we = 1'b1; addr = 8'h60; be = 4'h1; wdata = 32'h03;
    @(negedge clk);
    we = 1'b0; be = '0;
    chk("R6 old routing after write edge", 32'(irq), 32'h8000);
    @(negedge clk);
    chk("R6 new routing after next edge", 32'(irq), 32'h0008);

    // R3 disabled D high is ignored; R6 enabling picks up live level
    @(negedge clk);
    pirq = 4'b1001;
    repeat (2) @(negedge clk);
    chk("R3 disabled line ignored", 32'(irq), 32'h0008);
    cfg_write(8'h60, 4'h8, 32'h04000000);
    @(negedge clk);
    chk("R6 rebuild from live level", 32'(irq), 32'h0018);

    // R7 swizzle
    for (int s = 0; s < 8; s++) begin
      for (int ix = 0; ix < 4; ix++) begin
        devfn = 8'((s << 3) | (s & 7)); intx = 2'(ix); #1;
        chk("R7 swizzle", 32'(spirq), 32'((ix + s + 3) % 4));
      end
    end

    // R5 asynchronous reset mid-run
    @(negedge clk);
    rst_ni = 1'b0; #1;
    chk("R5 async clear irq", 32'(irq), 32'h0);
    qpin = 2'd3; #1;
    chk("R5 routes back to disabled", 32'({qen, qirq}), 32'h1F);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 R5 all disabled after reset", 32'(irq), 32'h0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule